// File: doc/BRIEF.md
# Low-Power Mode Controller

This block follows the operating mode of a small processor core. It keeps one state register that holds one of six modes: reset, full-rate active, divided active, sleep, standby and watch. It also produces two clock enables from the oscillator clock. The CPU enable is high on every cycle at full rate and high on one cycle in eight in the divided active mode. The peripheral enable stays high at the full oscillator rate whenever the peripherals run.

A SLEEP strobe from the core moves an active mode into a low-power mode. The strobe is decoded against the standby select (`ssby`), the low-speed select (`lson`) and the watch-timer select (`tma3`). Each low-power mode has its own set of wake sources. A wake event is a request whose own enable bit is set while the global interrupt mask is clear. It returns the controller to the divided active mode when `mson` is 1 and `lson` is 0, and to the full-rate mode otherwise.

States: RESET (0), ACT_HI (1), ACT_MED (2), SLEEP (3), STANDBY (4), WATCH (5).

Transitions:
- RESET→ACT_HI happens on the next clock.
- ACT_HI/ACT_MED→SLEEP, STANDBY or WATCH happens on a decoded SLEEP strobe.
- SLEEP, STANDBY or WATCH→ACT_HI or ACT_MED happens on a permitted wake event.
- Any state→RESET happens on a watchdog or external reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_o` is RESET (0) at once. A cycle with `wdt_rst`=1 sets `mode_o` to RESET on the next clock edge, whatever the mode. In RESET, both `cpu_ce` and `periph_ce` are 0.
- R2: One clock after RESET is left, `mode_o` is ACT_HI (1). In ACT_HI, `cpu_ce` and `periph_ce` are 1 on every cycle.
- R3: A `sleep_stb` in ACT_HI or ACT_MED selects the next mode as follows:
  - `ssby`=1 and `tma3`=1 enter WATCH (5).
  - `ssby`=1, `lson`=0 and `tma3`=0 enter STANDBY (4).
  - `ssby`=0 and `lson`=0 enter SLEEP (3).
- R4: A `sleep_stb` whose bits match no rule of R3 leaves the mode unchanged. A `sleep_stb` in SLEEP, STANDBY or WATCH also leaves the mode unchanged.
- R5: A wake event goes to ACT_MED (2) when `mson`=1 and `lson`=0, and to ACT_HI (1) otherwise.
- R6: In STANDBY, only `irq_req` bits 0 and 1 and any `wkp_req` bit wake the controller. `tmr_req`, `irq_req` bits 2 and above, and `per_req` have no effect.
- R7: In WATCH, only `tmr_req`, `irq_req` bit 0 and any `wkp_req` bit wake the controller. `irq_req` bit 1 has no effect.
- R8: In SLEEP, any enabled request wakes the controller: `irq_req`, `wkp_req`, `tmr_req` or `per_req`.
- R9: No wake occurs while `imask`=1, or while the requesting source's enable bit is 0.
- R10: In ACT_MED, `cpu_ce` is 1 on the 8th cycle after entry and then on every 8th cycle. `periph_ce` is 1 on every cycle in this mode. The divider restarts on every mode change.
- R11: In SLEEP, `cpu_ce` is 0 and `periph_ce` is 1. In STANDBY and WATCH, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| wdt_rst | input | 1 | Watchdog reset request, synchronous |
| mson | input | 1 | Divided active mode select for wake |
| lson | input | 1 | Low-speed select |
| ssby | input | 1 | Standby select |
| tma3 | input | 1 | Watch-timer select |
| sleep_stb | input | 1 | One-cycle SLEEP instruction strobe |
| imask | input | 1 | Global interrupt mask |
| irq_req | input | N_IRQ | External interrupt requests |
| irq_en | input | N_IRQ | External interrupt enables |
| wkp_req | input | N_WKP | Wake pin requests |
| wkp_en | input | N_WKP | Wake pin enables |
| tmr_req | input | 1 | Timer interrupt request |
| tmr_en | input | 1 | Timer interrupt enable |
| per_req | input | N_PER | Other peripheral requests |
| per_en | input | N_PER | Other peripheral enables |
| mode_o | output | 3 | Current mode encoding |
| cpu_ce | output | 1 | CPU clock enable |
| periph_ce | output | 1 | Peripheral clock enable |

## Verification
The mode register drives `mode_o` directly, so a wrong state shows on the port one clock after the edge that caused it. A corrupted divider count shows as a `cpu_ce` pulse early, late or missing within eight cycles of entering ACT_MED. A wake filter that admits a source it should not admit moves `mode_o` on the next edge. One that blocks a permitted source leaves `mode_o` unchanged in the cycle where the bench expects an active mode.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [2:0] {
        M_RESET   = 3'd0,
        M_ACT_HI  = 3'd1,
        M_ACT_MED = 3'd2,
        M_SLEEP   = 3'd3,
        M_STANDBY = 3'd4,
        M_WATCH   = 3'd5
    } mode_t;
endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter #(
    parameter int N_IRQ = 4,
    parameter int N_WKP = 8,
    parameter int N_PER = 4
) (
    input  logic             imask,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_WKP-1:0] wkp_req,
    input  logic [N_WKP-1:0] wkp_en,
    input  logic             tmr_req,
    input  logic             tmr_en,
    input  logic [N_PER-1:0] per_req,
    input  logic [N_PER-1:0] per_en,
    output logic             wake_any,
    output logic             wake_stby,
    output logic             wake_watch
);
    logic [N_IRQ-1:0] irq_hit;
    logic [N_IRQ-1:0] stby_sel;
    logic             wkp_hit;
    logic             tmr_hit;
    logic             per_hit;

    // standby accepts only the two lowest external interrupts
    for (genvar i = 0; i < N_IRQ; i++) begin : g_sel
        assign stby_sel[i] = (i < 2);
    end

    assign irq_hit = irq_req & irq_en;
    assign wkp_hit = |(wkp_req & wkp_en);
    assign tmr_hit = tmr_req & tmr_en;
    assign per_hit = |(per_req & per_en);

    assign wake_any   = ~imask & ((|irq_hit) | wkp_hit | tmr_hit | per_hit);
    assign wake_stby  = ~imask & ((|(irq_hit & stby_sel)) | wkp_hit);
    assign wake_watch = ~imask & (irq_hit[0] | wkp_hit | tmr_hit);
endmodule

// File: rtl/pwr_sleep_decode.sv
module pwr_sleep_decode
    import pwr_mode_pkg::*;
(
    input  logic  ssby,
    input  logic  lson,
    input  logic  tma3,
    output logic  hit,
    output mode_t target
);
    always_comb begin
        hit    = 1'b1;
        target = M_SLEEP;
        if (ssby && tma3)
            target = M_WATCH;
        else if (ssby && !lson)
            target = M_STANDBY;
        else if (!ssby && !lson)
            target = M_SLEEP;
        else
            hit = 1'b0;
    end
endmodule

// File: rtl/pwr_clk_div.sv
module pwr_clk_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || !run || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int N_WKP = 8,
    parameter int N_PER = 4,
    parameter int DIV   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_rst,
    input  logic             mson,
    input  logic             lson,
    input  logic             ssby,
    input  logic             tma3,
    input  logic             sleep_stb,
    input  logic             imask,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_WKP-1:0] wkp_req,
    input  logic [N_WKP-1:0] wkp_en,
    input  logic             tmr_req,
    input  logic             tmr_en,
    input  logic [N_PER-1:0] per_req,
    input  logic [N_PER-1:0] per_en,
    output logic [2:0]       mode_o,
    output logic             cpu_ce,
    output logic             periph_ce
);
    mode_t mode_q, mode_d, slp_target, wake_dst;
    logic  slp_hit, wake_any, wake_stby, wake_watch, div_tick;

    pwr_wake_filter #(.N_IRQ(N_IRQ), .N_WKP(N_WKP), .N_PER(N_PER)) u_wake (
        .imask(imask), .irq_req(irq_req), .irq_en(irq_en),
        .wkp_req(wkp_req), .wkp_en(wkp_en), .tmr_req(tmr_req), .tmr_en(tmr_en),
        .per_req(per_req), .per_en(per_en),
        .wake_any(wake_any), .wake_stby(wake_stby), .wake_watch(wake_watch)
    );

    pwr_sleep_decode u_dec (
        .ssby(ssby), .lson(lson), .tma3(tma3), .hit(slp_hit), .target(slp_target)
    );

    pwr_clk_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(mode_q == M_ACT_MED),
        .clr(mode_d != mode_q), .tick(div_tick)
    );

    assign wake_dst = (mson && !lson) ? M_ACT_MED : M_ACT_HI;

    always_comb begin
        mode_d = mode_q;
        if (wdt_rst) begin
            mode_d = M_RESET;
        end else begin
            unique case (mode_q)
                M_RESET:   mode_d = M_ACT_HI;
                M_ACT_HI,
                M_ACT_MED: if (sleep_stb && slp_hit) mode_d = slp_target;
                M_SLEEP:   if (wake_any)   mode_d = wake_dst;
                M_STANDBY: if (wake_stby)  mode_d = wake_dst;
                M_WATCH:   if (wake_watch) mode_d = wake_dst;
                default:   mode_d = M_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_RESET;
        else        mode_q <= mode_d;
    end

    always_comb begin
        cpu_ce    = 1'b0;
        periph_ce = 1'b0;
        unique case (mode_q)
            M_ACT_HI:  begin cpu_ce = 1'b1;     periph_ce = 1'b1; end
            M_ACT_MED: begin cpu_ce = div_tick; periph_ce = 1'b1; end
            M_SLEEP:   periph_ce = 1'b1;
            default:   ;
        endcase
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
    parameter int DIV = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wdt_rst,
    input logic       imask,
    input logic       sleep_stb,
    input logic [2:0] mode_o,
    input logic       cpu_ce,
    input logic       periph_ce
);
    localparam int GW = $clog2(DIV + 1) + 1;
    logic [GW-1:0] gap;
    logic          low_pwr;

    assign low_pwr = (mode_o == 3'd3) || (mode_o == 3'd4) || (mode_o == 3'd5);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          gap <= '0;
        else if (mode_o != 3'd2 || cpu_ce)   gap <= '0;
        else                                 gap <= gap + 1'b1;
    end

    a_r1_wdt_reset: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> mode_o == 3'd0);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd0 |-> !cpu_ce && !periph_ce);
    a_r2_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && !wdt_rst) |=> mode_o == 3'd1);
    a_r9_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (low_pwr && imask && !wdt_rst) |=> $stable(mode_o));
    a_r10_ce_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd2 |-> gap < GW'(DIV));
    a_r10_periph_on: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd2 |-> periph_ce);
    a_r11_lp_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
        low_pwr |-> !cpu_ce);
    a_r4_lp_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (low_pwr && imask && sleep_stb && !wdt_rst) |=> $stable(mode_o));
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.DIV(DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .imask(imask),
    .sleep_stb(sleep_stb), .mode_o(mode_o), .cpu_ce(cpu_ce), .periph_ce(periph_ce)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
    localparam int N_IRQ = 4, N_WKP = 8, N_PER = 4, DIV = 8;

    logic clk = 1'b0, rst_n = 1'b0, wdt_rst = 1'b0;
    logic mson = 0, lson = 0, ssby = 0, tma3 = 0, sleep_stb = 0, imask = 0;
    logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
    logic [N_WKP-1:0] wkp_req = '0, wkp_en = '0;
    logic             tmr_req = 0, tmr_en = 0;
    logic [N_PER-1:0] per_req = '0, per_en = '0;
    logic [2:0] mode_o;
    logic cpu_ce, periph_ce;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(N_IRQ), .N_WKP(N_WKP), .N_PER(N_PER), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .mson(mson), .lson(lson),
        .ssby(ssby), .tma3(tma3), .sleep_stb(sleep_stb), .imask(imask),
        .irq_req(irq_req), .irq_en(irq_en), .wkp_req(wkp_req), .wkp_en(wkp_en),
        .tmr_req(tmr_req), .tmr_en(tmr_en), .per_req(per_req), .per_en(per_en),
        .mode_o(mode_o), .cpu_ce(cpu_ce), .periph_ce(periph_ce)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_req();
        irq_req = '0; wkp_req = '0; tmr_req = 0; per_req = '0;
    endtask

    task automatic go_hi();
        clr_req(); imask = 0;
        wdt_rst = 1; step(1); wdt_rst = 0; step(1);
    endtask

    task automatic go_low(input logic s, input logic l, input logic t);
        ssby = s; lson = l; tma3 = t; sleep_stb = 1; step(1); sleep_stb = 0;
    endtask

    task automatic t_reset();
        chk("R1 ext reset mode", mode_o, 0);
        chk("R1 reset cpu_ce", cpu_ce, 0);
        chk("R1 reset periph_ce", periph_ce, 0);
        rst_n = 1; step(1);
        chk("R2 exit to ACT_HI", mode_o, 1);
        chk("R2 cpu_ce", cpu_ce, 1);
        step(1);
        chk("R2 cpu_ce every cycle", cpu_ce, 1);
        chk("R2 periph_ce", periph_ce, 1);
    endtask

    task automatic t_sleep_decode();
        go_hi(); go_low(0, 0, 0);
        chk("R3 sleep", mode_o, 3);
        chk("R11 sleep cpu_ce", cpu_ce, 0);
        chk("R11 sleep periph_ce", periph_ce, 1);
        go_hi(); go_low(1, 0, 0);
        chk("R3 standby", mode_o, 4);
        chk("R11 standby periph_ce", periph_ce, 0);
        go_hi(); go_low(1, 1, 1);
        chk("R3 watch with lson=1", mode_o, 5);
        chk("R11 watch cpu_ce", cpu_ce, 0);
        go_hi(); go_low(1, 0, 1);
        chk("R3 watch with lson=0", mode_o, 5);
    endtask

    task automatic t_unmatched();
        go_hi(); go_low(1, 1, 0);
        chk("R4 ssby=1 lson=1 tma3=0 unchanged", mode_o, 1);
        go_low(0, 1, 0);
        chk("R4 ssby=0 lson=1 unchanged", mode_o, 1);
        go_low(0, 0, 0);
        go_low(1, 0, 1);
        chk("R4 strobe in SLEEP ignored", mode_o, 3);
    endtask

    task automatic t_wake_sleep();
        go_hi(); go_low(0, 0, 0); mson = 0; lson = 0;
        per_en = 4'b0100; per_req = 4'b0100; step(1); clr_req();
        chk("R8 peripheral wakes sleep, R5 to ACT_HI", mode_o, 1);
        go_low(0, 0, 0); mson = 1;
        irq_en[3] = 1; irq_req[3] = 1; step(1); clr_req();
        chk("R8 irq3 wakes sleep, R5 to ACT_MED", mode_o, 2);
        go_low(0, 0, 0); lson = 1;
        tmr_en = 1; tmr_req = 1; step(1); clr_req();
        chk("R5 lson=1 wakes to ACT_HI", mode_o, 1);
        lson = 0; mson = 0;
    endtask

    task automatic t_wake_standby();
        go_hi(); go_low(1, 0, 0);
        tmr_en = 1; tmr_req = 1; irq_en = '1; irq_req = 4'b1100;
        per_en = '1; per_req = '1; step(2); clr_req();
        chk("R6 standby ignores timer/irq2+/periph", mode_o, 4);
        irq_req[1] = 1; step(1); clr_req();
        chk("R6 irq1 wakes standby", mode_o, 1);
        go_low(1, 0, 0);
        wkp_en[6] = 1; wkp_req[6] = 1; step(1); clr_req();
        chk("R6 wkp6 wakes standby", mode_o, 1);
    endtask

    task automatic t_wake_watch();
        go_hi(); go_low(1, 0, 1);
        irq_en = '1; irq_req[1] = 1; step(2); clr_req();
        chk("R7 watch ignores irq1", mode_o, 5);
        tmr_en = 1; tmr_req = 1; step(1); clr_req();
        chk("R7 timer wakes watch", mode_o, 1);
        go_low(1, 0, 1);
        irq_req[0] = 1; step(1); clr_req();
        chk("R7 irq0 wakes watch", mode_o, 1);
    endtask

    task automatic t_mask();
        go_hi(); go_low(0, 0, 0);
        imask = 1; irq_en = '1; irq_req = '1; step(2);
        chk("R9 imask blocks wake", mode_o, 3);
        imask = 0; irq_req = '0; wkp_en = '0; wkp_req = '1;
        per_en = '0; per_req = '1; tmr_en = 0; tmr_req = 1; step(2);
        chk("R9 disabled sources block wake", mode_o, 3);
        clr_req();
    endtask

    task automatic t_medium();
        go_hi(); go_low(0, 0, 0); mson = 1;
        wkp_en[0] = 1; wkp_req[0] = 1; step(1); clr_req();
        chk("R10 entered ACT_MED", mode_o, 2);
        for (int k = 0; k < 7; k++) begin
            chk("R10 no cpu_ce before 8th cycle", cpu_ce, 0);
            chk("R10 periph_ce on", periph_ce, 1);
            step(1);
        end
        chk("R10 cpu_ce on 8th cycle", cpu_ce, 1);
        step(1);
        chk("R10 cpu_ce drops", cpu_ce, 0);
        step(7);
        chk("R10 cpu_ce on 16th cycle", cpu_ce, 1);
        step(3);
        go_low(0, 0, 0);
        wkp_req[0] = 1; step(1); clr_req();
        chk("R10 re-entered ACT_MED", mode_o, 2);
        step(7);
        chk("R10 divider restarted on mode change", cpu_ce, 1);
        mson = 0;
    endtask

    task automatic t_watchdog();
        go_hi(); go_low(1, 0, 0);
        wdt_rst = 1; step(1);
        chk("R1 watchdog from STANDBY", mode_o, 0);
        chk("R1 watchdog cpu_ce", cpu_ce, 0);
        wdt_rst = 0; step(1);
        chk("R2 back to ACT_HI", mode_o, 1);
        #5 rst_n = 0; #1;
        chk("R1 async ext reset", mode_o, 0);
        step(2); rst_n = 1; step(1);
        chk("R2 after ext reset", mode_o, 1);
    endtask

    initial begin
        step(3);
        t_reset();
        t_sleep_decode();
        t_unmatched();
        t_wake_sleep();
        t_wake_standby();
        t_wake_watch();
        t_mask();
        t_medium();
        t_watchdog();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule